// File: doc/BRIEF.md
# Up-Counting Timer with Update-Event Logic

This block is a free-running up-counter driven through a programmable clock divider. The counter climbs to a programmed reload limit and then wraps to zero. The wrap is an update event: it copies the staged divider and limit values into the working registers and raises a status flag. Software can also force an update event through a self-clearing request bit. That request restarts the counter and the divider at once. It raises the same flag only if the source-select bit allows it, and only after a short fixed delay.

The block has a plain register port. A write is one cycle with `wr_en` high. A read is combinational through `rd_addr` and `rd_data`. No data stream crosses the block's edge, so it needs no back-pressure handshake. The single interrupt output follows the flag, gated by an enable bit.

Register offsets: 0 control (bit 0 run, bit 1 overflow-only source, bit 2 interrupt enable), 1 event request (bit 0 software update), 2 status (bit 0 update flag), 3 reload limit (staged), 4 divider (staged), 5 current count (read-only).

Top module: `tmr_upd_core`

## Requirements
- R1: After reset, control reads 0, status reads 0, the count reads 0, the staged reload reads all ones and `upd_irq` is 0.
- R2: With run=1, divider D and limit L, the count advances once every D+1 cycles. It wraps from L to 0, and every wrap sets the flag, whatever the source-select bit holds. Overflows are therefore (D+1)*(L+1) cycles apart.
- R3: New values written to offsets 3 and 4 take effect only at the next update event. The current period finishes with the old limit.
- R4: Writing 1 to bit 0 at offset 1 clears the count and the divider's internal phase on that clock edge, even when run=0. The divide ratio itself is unchanged. With run=0 the count holds.
- R5: Bit 0 at offset 1 reads 1 for the single cycle after a request and 0 afterwards. Writing 0 there leaves the count unchanged.
- R6: With bit 1 of control at 0, a software update sets the flag exactly UPD_LAT (2) clock edges after the write edge, not earlier.
- R7: With bit 1 of control at 1, a software update reloads the counter but never sets the flag.
- R8: Writing 0 to bit 0 at offset 2 clears the flag. Writing 1 there has no effect.
- R9: When a flag clear and a flag set fall on the same edge, the flag ends set. A clear issued inside the software-update latency window is therefore overridden.
- R10: `upd_irq` is 1 exactly while the flag is 1 and bit 2 of control is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write offset |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Read offset |
| rd_data | output | DW | Combinational read data |
| upd_irq | output | 1 | Update interrupt request |

## Verification
Two things can land on the same edge: the delayed flag set from a software update, and a software write that clears the flag. The bench issues a software update with the source bit at 0. It then writes clears on the first and second edges after it, so the second clear coincides with the delayed set, and it expects the flag to read 1. A further clear one edge later must read 0. The same clash is provoked against an overflow set by letting a short period wrap on the edge of a clear. There the flag must again survive.

// File: rtl/tmr_upd_pkg.sv
package tmr_upd_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_EVREQ  = 3'd1,
    RA_STAT   = 3'd2,
    RA_RELOAD = 3'd3,
    RA_DIV    = 3'd4,
    RA_COUNT  = 3'd5
  } reg_addr_e;

  localparam int CB_RUN     = 0;
  localparam int CB_OVFONLY = 1;
  localparam int CB_IE      = 2;
  localparam int CTRL_W     = 3;

  typedef struct packed {
    logic ie;
    logic ovf_only;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] phase_q;

  assign tick = run && !restart && (phase_q == ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (phase_q == ratio) phase_q <= '0;
      else                  phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign value = cnt_q;
  assign wrap  = tick && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == limit) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_upd_flag.sv
module tmr_upd_flag #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic hw_set,
  input  logic clr_req,
  output logic sw_set,
  output logic flag
);
  generate
    if (LAT == 0) begin : g_direct
      assign sw_set = sw_req;
    end else begin : g_pipe
      logic [LAT-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else if (LAT == 1) pipe_q <= sw_req;
        else pipe_q <= {pipe_q[LAT-2:0], sw_req};
      end
      assign sw_set = pipe_q[LAT-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (sw_set || hw_set) flag <= 1'b1;
    else if (clr_req)          flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_upd_core.sv
module tmr_upd_core #(
  parameter int DW      = 16,
  parameter int UPD_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [tmr_upd_pkg::ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic [tmr_upd_pkg::ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]                 rd_data,
  output logic                          upd_irq
);
  import tmr_upd_pkg::*;

  ctrl_t        ctrl_q;
  logic [DW-1:0] reload_stg_q, div_stg_q;
  logic [DW-1:0] reload_act_q, div_act_q;
  logic          req_rb_q;
  logic          sw_hit, sw_flag_req, clr_hit;
  logic          tick, wrap, upd_evt, sw_set, flag_q;
  logic [DW-1:0] count;

  assign sw_hit      = wr_en && (wr_addr == RA_EVREQ) && wr_data[0];
  assign sw_flag_req = sw_hit && !ctrl_q.ovf_only;
  assign clr_hit     = wr_en && (wr_addr == RA_STAT) && !wr_data[0];
  assign upd_evt     = sw_hit || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      reload_stg_q <= '1;
      div_stg_q    <= '0;
      req_rb_q     <= 1'b0;
    end else begin
      req_rb_q <= sw_hit;
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL:   ctrl_q       <= ctrl_t'(wr_data[CTRL_W-1:0]);
          RA_RELOAD: reload_stg_q <= wr_data;
          RA_DIV:    div_stg_q    <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_act_q <= '1;
      div_act_q    <= '0;
    end else if (upd_evt) begin
      reload_act_q <= reload_stg_q;
      div_act_q    <= div_stg_q;
    end
  end

  tmr_prescaler #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(sw_hit), .run(ctrl_q.run),
    .ratio(div_act_q), .tick(tick)
  );

  tmr_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sw_hit), .tick(tick),
    .limit(reload_act_q), .value(count), .wrap(wrap)
  );

  tmr_upd_flag #(.LAT(UPD_LAT)) u_flag (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_flag_req), .hw_set(wrap),
    .clr_req(clr_hit), .sw_set(sw_set), .flag(flag_q)
  );

  assign upd_irq = flag_q && ctrl_q.ie;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
      RA_EVREQ:  rd_data[0] = req_rb_q;
      RA_STAT:   rd_data[0] = flag_q;
      RA_RELOAD: rd_data = reload_stg_q;
      RA_DIV:    rd_data = div_stg_q;
      RA_COUNT:  rd_data = count;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_upd_chk.sv
module tmr_upd_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_hit,
  input logic          clr_hit,
  input logic          run,
  input logic          wrap,
  input logic          sw_set,
  input logic          flag,
  input logic          irq,
  input logic [DW-1:0] count
);
  // R2
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  // R9
  sw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> flag);
  // R8
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_hit));
  // R4
  sw_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> (count == '0));
  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_hit) |=> $stable(count));
  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind tmr_upd_core tmr_upd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_hit(sw_hit), .clr_hit(clr_hit),
  .run(ctrl_q.run), .wrap(wrap), .sw_set(sw_set), .flag(flag_q),
  .irq(upd_irq), .count(count)
);

// File: tb/tmr_upd_core_tb_top.sv
module tmr_upd_core_tb_top;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic upd_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  tmr_upd_core #(.DW(DW), .UPD_LAT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .upd_irq(upd_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic wait_flag(output int n);
    int v;
    n = -1;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk); #2;
      rd(2, v);
      if (v[0]) begin n = k; break; end
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 stat", v, 0);
    rd(5, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 reload", v, 16'hFFFF);
    chk("R1 irq", upd_irq, 0);

    // R2 sweep of divider and limit, overflow-only source
    for (int d = 0; d <= 2; d++) begin
      for (int l = 0; l <= 3; l++) begin
        wr(0, 16'd2); wr(4, d[15:0]); wr(3, l[15:0]);
        wr(1, 16'd1); wr(2, 16'd0); wr(0, 16'd3);
        wait_flag(n);
        chk($sformatf("R2 period d=%0d l=%0d", d, l), n, (d + 1) * (l + 1));
        rd(5, v); chk("R2 wrap to zero", v, 0);
      end
    end

    // R3 staged limit used only after the update
    wr(0, 16'd2); wr(4, 16'd0); wr(3, 16'd3); wr(1, 16'd1); wr(2, 16'd0);
    wr(3, 16'd1); wr(0, 16'd3);
    wait_flag(n); chk("R3 old limit period", n, 4);
    wr(2, 16'd0);
    wait_flag(n); chk("R3 new limit period", n, 1);

    // R4/R5 restart while stopped, write of 0 ignored
    wr(0, 16'd2); wr(4, 16'd0); wr(3, 16'd100); wr(1, 16'd1); wr(2, 16'd0);
    wr(0, 16'd3);
    repeat (10) edge1();
    wr(0, 16'd2);
    rd(5, v); chk("R4 counted", v, 11);
    wr(1, 16'd0);
    rd(5, v); chk("R5 zero write ignored", v, 11);
    rd(1, v); chk("R5 no request readback", v, 0);
    repeat (3) edge1();
    rd(5, v); chk("R4 holds when stopped", v, 11);
    wr(1, 16'd1);
    rd(5, v); chk("R4 restart when stopped", v, 0);
    rd(1, v); chk("R5 request readback", v, 1);
    edge1();
    rd(1, v); chk("R5 self clear", v, 0);
    repeat (4) edge1();
    rd(2, v); chk("R7 no flag on sw update", v, 0);

    // R4 divider phase cleared, ratio kept
    wr(4, 16'd3); wr(1, 16'd1); wr(0, 16'd3);
    edge1(); edge1();
    wr(1, 16'd1);
    repeat (3) edge1();
    rd(5, v); chk("R4 phase cleared", v, 0);
    edge1();
    rd(5, v); chk("R4 ratio kept", v, 1);

    // R6 latency
    wr(0, 16'd0); wr(2, 16'd0);
    wr(1, 16'd1);
    rd(2, v); chk("R6 flag at +0", v, 0);
    edge1(); rd(2, v); chk("R6 flag at +1", v, 0);
    edge1(); rd(2, v); chk("R6 flag at +2", v, 1);

    // R8 write 1 no effect, write 0 clears
    wr(2, 16'd1); rd(2, v); chk("R8 write 1 keeps set", v, 1);
    wr(2, 16'd0); rd(2, v); chk("R8 clear", v, 0);
    wr(2, 16'd1); rd(2, v); chk("R8 write 1 keeps clear", v, 0);

    // R9 clear within latency window overridden
    wr(1, 16'd1); wr(2, 16'd0); wr(2, 16'd0);
    rd(2, v); chk("R9 set wins over clear", v, 1);
    wr(2, 16'd0); rd(2, v); chk("R9 later clear", v, 0);

    // R9 overflow against clear: limit 0, divider 0 wraps every edge
    wr(0, 16'd2); wr(4, 16'd0); wr(3, 16'd0); wr(1, 16'd1); wr(0, 16'd3);
    wr(2, 16'd0);
    rd(2, v); chk("R9 overflow set wins", v, 1);
    wr(0, 16'd2);

    // R10 interrupt gating
    wr(2, 16'd0); wr(0, 16'd4); wr(1, 16'd1); edge1(); edge1();
    chk("R10 irq high", upd_irq, 1);
    wr(0, 16'd0); chk("R10 irq masked", upd_irq, 0);
    wr(2, 16'd0); wr(0, 16'd4); chk("R10 irq no flag", upd_irq, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule